// File: doc/BRIEF.md
# Multi-Channel Relaxed Shared Memory

This block is a synthesizable behavioural stand-in for a shared memory that an accelerator reaches through several independent channels, with weak ordering between them. The accelerator posts writes, reads, single-channel fences and all-channel fences, each carrying a tag, and receives tagged responses. Every request first waits in a pool: reads in one pool, writes and fences together in another. A pseudo-random arbiter moves entries from a pool into a channel's upstream queue out of arrival order. Each channel drains to the memory array in strict order of its own, but channels drain independently of one another.

A write is acknowledged as soon as it enters its channel, which can be before it lands in memory. Only a fence guarantees that earlier writes are visible. A second, CPU-side port reads and writes the same array directly and coherently. Test benches and system models use the block to expose software and hardware to the reorderings that real multi-channel links allow, and a seed input makes each run reproducible.

Top module: `relaxed_chan_mem`

## Requirements
- R1: While reset is held, rsp_valid is low and req_ready is high. After reset every memory location reads zero, both on the CPU port and through a channel read.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is low when the target pool (the read pool for reads, the write pool otherwise) already holds POOL_D entries. A stalled request is not lost.
- R3: Request and response kinds share one 2-bit code: 0 write, 1 read, 2 fence on one channel, 3 fence on all channels.
- R4: A write is answered with kind 0, its own channel and its own tag when it moves from the write pool into its channel.
- R5: A one-channel fence is answered (kind 2, its channel, its tag) only once every write on that channel requested before it has been written to memory. Those values are then visible on the CPU port.
- R6: An all-channel fence is answered (kind 3, channel 0, its tag) only once every earlier write on every channel is in memory.
- R7: A read is answered with kind 1, its channel, its tag, and the memory value sampled when the read leaves its upstream queue. Entries within one channel reach memory in the order they entered it.
- R8: cpu_rdata shows the addressed location combinationally. A CPU write is visible from the next cycle and wins over a channel write to the same cycle.
- R9: Responses leave on one registered port, at most one per cycle. Every accepted request yields exactly one response.
- R10: Pool selection and channel drain order come from a 16-bit LFSR loaded from seed during reset, with a zero seed replaced by 1. The same seed and the same stimulus give the same response order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed | input | 16 | Arbiter seed, loaded during reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target pool has room |
| req_kind | input | 2 | Request kind code |
| req_ch | input | CW (2) | Target channel |
| req_addr | input | AW (4) | Location |
| req_data | input | DW (8) | Write value |
| req_tag | input | TW (4) | Request tag |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_kind | output | 2 | Response kind code |
| rsp_ch | output | CW (2) | Response channel |
| rsp_data | output | DW (8) | Read value, zero otherwise |
| rsp_tag | output | TW (4) | Tag of the answered request |
| cpu_we | input | 1 | CPU-side write enable |
| cpu_addr | input | AW (4) | CPU-side location |
| cpu_wdata | input | DW (8) | CPU-side write value |
| cpu_rdata | output | DW (8) | CPU-side read value |

## Verification
A pool or queue that drops, duplicates or corrupts an entry shows up as a missing response, a duplicate response or a wrong tag. The bench detects this within a few thousand cycles through per-tag bookkeeping and a final request-versus-response count. A fence that completes too early leaves stale data on the CPU port on the cycle the fence response is seen. That is checked at every location on every channel. A drain that reads the wrong entry or slot gives a wrong value in the read sweep. A broken LFSR load changes the response order between two runs with the same seed.

// File: rtl/relaxed_chan_mem.sv
module relaxed_chan_mem #(
  parameter int NCH    = 3,
  parameter int POOL_D = 8,
  parameter int Q_D    = 4,
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int TW     = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [15:0]                       seed,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [1:0]                        req_kind,
  input  logic [((NCH>1)?$clog2(NCH):1)-1:0] req_ch,
  input  logic [AW-1:0]                     req_addr,
  input  logic [DW-1:0]                     req_data,
  input  logic [TW-1:0]                     req_tag,
  output logic                              rsp_valid,
  output logic [1:0]                        rsp_kind,
  output logic [((NCH>1)?$clog2(NCH):1)-1:0] rsp_ch,
  output logic [DW-1:0]                     rsp_data,
  output logic [TW-1:0]                     rsp_tag,
  input  logic                              cpu_we,
  input  logic [AW-1:0]                     cpu_addr,
  input  logic [DW-1:0]                     cpu_wdata,
  output logic [DW-1:0]                     cpu_rdata
);
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PIW = $clog2(POOL_D);
  localparam int PCW = $clog2(POOL_D + 1);
  localparam int QIW = $clog2(Q_D);
  localparam int QCW = $clog2(Q_D + 1);
  localparam int MD  = 1 << AW;
  localparam logic [PCW-1:0] PFULL = PCW'(POOL_D);
  localparam logic [QCW-1:0] QFULL = QCW'(Q_D);
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_FA = 2'd3;

  logic [DW-1:0]  mem [MD];
  logic [15:0]    lfsr;
  logic [PCW-1:0] rcnt, wcnt;
  logic [CW-1:0]  rp_ch [POOL_D];
  logic [AW-1:0]  rp_a  [POOL_D];
  logic [TW-1:0]  rp_t  [POOL_D];
  logic [1:0]     wp_k  [POOL_D];
  logic [CW-1:0]  wp_ch [POOL_D];
  logic [AW-1:0]  wp_a  [POOL_D];
  logic [DW-1:0]  wp_d  [POOL_D];
  logic [TW-1:0]  wp_t  [POOL_D];
  logic           uq_w  [NCH][Q_D];
  logic [AW-1:0]  uq_a  [NCH][Q_D];
  logic [DW-1:0]  uq_d  [NCH][Q_D];
  logic [TW-1:0]  uq_t  [NCH][Q_D];
  logic [QCW-1:0] ucnt  [NCH];

  logic [NCH-1:0] uwr;
  logic [PIW-1:0] ri, wi;
  logic [CW-1:0]  dc, rch, wch;
  logic [1:0]     wk;
  logic           older_ch, older_any, w_ok, do_rd, do_wr, do_dr;

  assign req_ready = (req_kind == K_RD) ? (rcnt != PFULL) : (wcnt != PFULL);
  assign cpu_rdata = mem[cpu_addr];
  wire acc_rd = req_valid && req_ready && req_kind == K_RD;
  wire acc_wr = req_valid && req_ready && req_kind != K_RD;

  always_comb begin
    uwr = '0;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < Q_D; i++)
        if (i < int'(ucnt[c]) && uq_w[c][i]) uwr[c] = 1'b1;
    ri  = (rcnt == 0) ? '0 : PIW'(int'(lfsr[7:0]) % int'(rcnt));
    wi  = (wcnt == 0) ? '0 : PIW'(int'(lfsr[11:4]) % int'(wcnt));
    dc  = CW'(int'(lfsr[15:12]) % NCH);
    rch = rp_ch[ri];
    wch = wp_ch[wi];
    wk  = wp_k[wi];
    older_ch = 1'b0;
    older_any = 1'b0;
    for (int j = 0; j < POOL_D; j++)
      if (j < int'(wi) && wp_k[j] == K_WR) begin
        older_any = 1'b1;
        if (wp_ch[j] == wch) older_ch = 1'b1;
      end
    case (wk)
      K_WR:    w_ok = ucnt[wch] != QFULL;
      K_FA:    w_ok = !older_any && uwr == '0;
      default: w_ok = !older_ch && !uwr[wch];
    endcase
    do_rd = lfsr[1:0] == 2'd1 && rcnt != 0 && ucnt[rch] != QFULL;
    do_wr = lfsr[1:0] == 2'd2 && wcnt != 0 && w_ok;
    do_dr = (lfsr[1:0] == 2'd0 || lfsr[1:0] == 2'd3) && ucnt[dc] != 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr      <= (seed == 16'd0) ? 16'd1 : seed;
      rcnt      <= '0;
      wcnt      <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_ch    <= '0;
      rsp_data  <= '0;
      rsp_tag   <= '0;
      for (int c = 0; c < NCH; c++) ucnt[c] <= '0;
      for (int m = 0; m < MD; m++) mem[m] <= '0;
    end else begin
      lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rsp_valid <= 1'b0;
      if (do_rd) begin
        for (int j = 0; j < POOL_D - 1; j++)
          if (j >= int'(ri)) begin
            rp_ch[j] <= rp_ch[j+1]; rp_a[j] <= rp_a[j+1]; rp_t[j] <= rp_t[j+1];
          end
        uq_w[rch][QIW'(ucnt[rch])] <= 1'b0;
        uq_a[rch][QIW'(ucnt[rch])] <= rp_a[ri];
        uq_d[rch][QIW'(ucnt[rch])] <= '0;
        uq_t[rch][QIW'(ucnt[rch])] <= rp_t[ri];
        ucnt[rch] <= ucnt[rch] + 1'b1;
      end
      if (acc_rd) begin
        rp_ch[PIW'(rcnt - PCW'(do_rd))] <= req_ch;
        rp_a[PIW'(rcnt - PCW'(do_rd))]  <= req_addr;
        rp_t[PIW'(rcnt - PCW'(do_rd))]  <= req_tag;
      end
      rcnt <= rcnt + PCW'(acc_rd) - PCW'(do_rd);
      if (do_wr) begin
        for (int j = 0; j < POOL_D - 1; j++)
          if (j >= int'(wi)) begin
            wp_k[j] <= wp_k[j+1]; wp_ch[j] <= wp_ch[j+1]; wp_a[j] <= wp_a[j+1];
            wp_d[j] <= wp_d[j+1]; wp_t[j] <= wp_t[j+1];
          end
        if (wk == K_WR) begin
          uq_w[wch][QIW'(ucnt[wch])] <= 1'b1;
          uq_a[wch][QIW'(ucnt[wch])] <= wp_a[wi];
          uq_d[wch][QIW'(ucnt[wch])] <= wp_d[wi];
          uq_t[wch][QIW'(ucnt[wch])] <= wp_t[wi];
          ucnt[wch] <= ucnt[wch] + 1'b1;
        end
        rsp_valid <= 1'b1;
        rsp_kind  <= wk;
        rsp_ch    <= wch;
        rsp_data  <= '0;
        rsp_tag   <= wp_t[wi];
      end
      if (acc_wr) begin
        wp_k[PIW'(wcnt - PCW'(do_wr))]  <= req_kind;
        wp_ch[PIW'(wcnt - PCW'(do_wr))] <= (req_kind == K_FA) ? '0 : req_ch;
        wp_a[PIW'(wcnt - PCW'(do_wr))]  <= (req_kind == K_WR) ? req_addr : '0;
        wp_d[PIW'(wcnt - PCW'(do_wr))]  <= (req_kind == K_WR) ? req_data : '0;
        wp_t[PIW'(wcnt - PCW'(do_wr))]  <= req_tag;
      end
      wcnt <= wcnt + PCW'(acc_wr) - PCW'(do_wr);
      if (do_dr) begin
        if (uq_w[dc][0]) mem[uq_a[dc][0]] <= uq_d[dc][0];
        else begin
          rsp_valid <= 1'b1;
          rsp_kind  <= K_RD;
          rsp_ch    <= dc;
          rsp_data  <= mem[uq_a[dc][0]];
          rsp_tag   <= uq_t[dc][0];
        end
        for (int i = 0; i < Q_D - 1; i++) begin
          uq_w[dc][i] <= uq_w[dc][i+1]; uq_a[dc][i] <= uq_a[dc][i+1];
          uq_d[dc][i] <= uq_d[dc][i+1]; uq_t[dc][i] <= uq_t[dc][i+1];
        end
        ucnt[dc] <= ucnt[dc] - 1'b1;
      end
      if (cpu_we) mem[cpu_addr] <= cpu_wdata;
    end
  end

  p_pool_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= PFULL && wcnt <= PFULL);
  p_stall_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && req_kind == K_RD |=> rcnt <= $past(rcnt));
  p_fence_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd2 |-> !$past(uwr[rsp_ch]));
  p_fence_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == K_FA |-> $past(uwr) == '0 && rsp_ch == '0);
  p_cpu_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> mem[$past(cpu_addr)] == $past(cpu_wdata));
  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_rd, do_wr, do_dr}));
  p_lfsr_alive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'd0);
  for (genvar g = 0; g < NCH; g++) begin : g_qchk
    p_queue_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ucnt[g] <= QFULL);
  end
endmodule

// File: tb/relaxed_chan_mem_bench.sv
module relaxed_chan_mem_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, cpu_we = 1'b0;
  logic [15:0] seed = 16'hACE1;
  logic [1:0] req_kind = '0, req_ch = '0;
  logic [3:0] req_addr = '0, req_tag = '0, cpu_addr = '0;
  logic [7:0] req_data = '0, cpu_wdata = '0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_kind, rsp_ch;
  logic [7:0] rsp_data, cpu_rdata;
  logic [3:0] rsp_tag;

  relaxed_chan_mem u_relaxed_chan_mem (
    .clk(clk), .rst_n(rst_n), .seed(seed), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_ch(req_ch), .req_addr(req_addr), .req_data(req_data),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_ch(rsp_ch),
    .rsp_data(rsp_data), .rsp_tag(rsp_tag), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  int n_run = 0, n_fail = 0, sent = 0, rsp_total = 0, ocnt = 0;
  logic seen [4][16];
  logic [1:0] s_ch [4][16];
  logic [7:0] s_dat [4][16];
  int ord [16];

  always @(negedge clk)
    if (rst_n && rsp_valid) begin
      seen[rsp_kind][rsp_tag] = 1'b1;
      s_ch[rsp_kind][rsp_tag] = rsp_ch;
      s_dat[rsp_kind][rsp_tag] = rsp_data;
      rsp_total++;
      if (rsp_kind == 2'd1 && ocnt < 16) begin ord[ocnt] = int'(rsp_tag); ocnt++; end
    end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_seen();
    for (int k = 0; k < 4; k++) for (int t = 0; t < 16; t++) seen[k][t] = 1'b0;
    ocnt = 0;
  endtask

  task automatic send(input logic [1:0] k, input int ch, input int a, input int d, input int t);
    @(negedge clk);
    req_kind = k; req_ch = 2'(ch); req_addr = 4'(a); req_data = 8'(d); req_tag = 4'(t);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    sent++;
  endtask

  task automatic wait_rsp(input int k, input int t, output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk); #2;
      if (seen[k][t]) got = 1'b1;
    end
  endtask

  task automatic do_reset(input logic [15:0] s);
    bit got;
    got = 1'b0;
    chk("R9 one response per request", rsp_total, sent);
    @(negedge clk);
    rst_n = 1'b0; seed = s; req_valid = 1'b0; cpu_we = 1'b0; cpu_addr = 4'd5;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
    chk("R1 req_ready in reset", int'(req_ready), 1);
    chk("R1 memory cleared", int'(cpu_rdata), 0);
    rst_n = 1'b1;
    sent = 0; rsp_total = 0;
    clear_seen();
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic run_order(output int o [8]);
    bit got;
    do_reset(16'h3C5A);
    for (int i = 0; i < 8; i++) send(2'd1, i % 3, i, 0, i);
    for (int i = 0; i < 8; i++) begin
      wait_rsp(1, i, got);
      chk("R1 read after reset is zero", got ? int'(s_dat[1][i]) : -1, 0);
    end
    for (int i = 0; i < 8; i++) o[i] = ord[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    report();
    $finish;
  end

  initial begin
    bit got;
    int o1 [8], o2 [8];
    int rd_seen;
    got = 1'b0;
    do_reset(16'hACE1);

    // R3 R4 R5: write then single-channel fence at every channel and location
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 16; a++) begin
        send(2'd0, c, a, (a * 7 + c * 29 + 3) & 255, a);
        wait_rsp(0, a, got);
        chk("R4 write response channel", got ? int'(s_ch[0][a]) : -1, c);
        send(2'd2, c, 0, 0, a);
        wait_rsp(2, a, got);
        chk("R5 fence response channel", got ? int'(s_ch[2][a]) : -1, c);
        cpu_addr = 4'(a); #1;
        chk("R5 data visible after fence", int'(cpu_rdata), (a * 7 + c * 29 + 3) & 255);
        seen[0][a] = 1'b0; seen[2][a] = 1'b0;
      end

    // R2 R7: sixteen reads back to back overflow the read pool
    clear_seen();
    for (int a = 0; a < 16; a++) send(2'd1, a % 3, a, 0, a);
    for (int a = 0; a < 16; a++) begin
      wait_rsp(1, a, got);
      chk("R7 read value", got ? int'(s_dat[1][a]) : -1, (a * 7 + 2 * 29 + 3) & 255);
      chk("R7 read channel", got ? int'(s_ch[1][a]) : -1, a % 3);
    end
    rd_seen = ocnt;
    chk("R2 every stalled read answered once", rd_seen, 16);

    // R6: writes spread over channels, one all-channel fence
    clear_seen();
    for (int a = 0; a < 6; a++) send(2'd0, a % 3, a, 8'h80 | a, a);
    send(2'd3, 2, 0, 0, 9);
    wait_rsp(3, 9, got);
    chk("R6 fence-all answered", int'(got), 1);
    chk("R6 fence-all channel zero", got ? int'(s_ch[3][9]) : -1, 0);
    for (int a = 0; a < 6; a++) begin
      cpu_addr = 4'(a); #1;
      chk("R6 data visible after fence-all", int'(cpu_rdata), 8'h80 | a);
    end

    // R8: CPU write visible next cycle and through a channel read
    @(negedge clk);
    cpu_addr = 4'd9; cpu_wdata = 8'h5A; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; #1;
    chk("R8 cpu write visible", int'(cpu_rdata), 8'h5A);
    send(2'd1, 1, 9, 0, 3);
    wait_rsp(1, 3, got);
    chk("R8 channel read sees cpu write", got ? int'(s_dat[1][3]) : -1, 8'h5A);

    // R10: same seed and stimulus reproduce the response order
    run_order(o1);
    run_order(o2);
    for (int i = 0; i < 8; i++) chk("R10 reproducible order", o2[i], o1[i]);

    repeat (20) @(negedge clk);
    chk("R9 one response per request", rsp_total, sent);
    report();
    $finish;
  end
endmodule